// File: doc/BRIEF.md
# Sleep Mode and Clock Gating Controller

This block is the power manager of a small microcontroller. Software puts a 3-bit code for the wanted sleep depth on `mode_sel` and strobes `sleep_req`. The controller then leaves the running state and drives four domain clock enables for the chosen depth: CPU clock, I/O clock, timer-2 clock and main-oscillator enable. A wake event brings it back. The two shallow depths return on the next clock. The deep depths first pass through a wake-up countdown, and the CPU clock stays off until the countdown ends.

The controller also holds a per-peripheral gating register. A set bit stops that peripheral's clock, and the peripheral's state stays frozen because it receives no edges. A set bit also blocks every bus read and write aimed at that peripheral: a blocked read returns zero and a blocked write is dropped. When the bit is cleared, the clock returns. The register only matters while the I/O clock runs, which is in the running and Idle states. In every deeper depth all peripheral clocks are off anyway.

The controller has three states. ACTIVE is the running state. SLEEP means a depth is in force. WAKE means the countdown is running. There are four transitions:
- sleep entry: ACTIVE to SLEEP, on `sleep_req` with a valid code.
- shallow wake: SLEEP to ACTIVE, on `wake_evt` in Idle or ADC-quiet.
- deep wake: SLEEP to WAKE, on `wake_evt` in any other depth.
- countdown end: WAKE to ACTIVE, when the counter reaches zero.

Top module: `pwr_sleep_ctrl`

## Requirements
- R1: After reset the state is ACTIVE. In ACTIVE, `cpu_clk_en`, `io_clk_en`, `t2_clk_en` and `osc_en` are 1, `periph_clk_en` is all ones, and `wake_done` is 0.
- R2: A `sleep_req` with code 3'b100 or 3'b101 is ignored, and the block stays in ACTIVE.
- R3: Code 3'b000 (Idle) gives cpu=0, io=1, t2=1 and osc=1. Peripheral clocks follow the gating register. A wake event returns the block to ACTIVE at the next edge.
- R4: Code 3'b001 (ADC-quiet) gives cpu=0, io=0 and osc=1, with t2 equal to `t2_async`. A wake event returns the block to ACTIVE at the next edge.
- R5: Code 3'b010 (Power-down) gives all four enables 0. Waking from it takes SLOW_WAKE cycles in WAKE.
- R6: Code 3'b011 (Power-save) gives cpu, io and osc equal to 0, with t2 equal to `t2_async`. The timer-2 clock runs only if the timer uses its asynchronous source. Waking takes SLOW_WAKE cycles.
- R7: Code 3'b110 with `xtal_opt`=1 (Standby) is Power-down with osc=1. Waking takes FAST_WAKE (default 6) cycles.
- R8: Code 3'b111 with `xtal_opt`=1 (Extended Standby) is Power-save with osc=1. Waking takes FAST_WAKE cycles.
- R9: Codes 3'b110 and 3'b111 with `xtal_opt`=0 fall back to Power-down and Power-save. In both cases osc=0 and the wake-up is slow.
- R10: In WAKE, osc=1, cpu=0 and io=0, and t2 keeps its sleep value. WAKE lasts exactly N cycles after the edge that samples the wake event. `wake_done` is 1 for exactly the first ACTIVE cycle after any wake.
- R11: The following have no effect on the state or the outputs:
  - a wake event during WAKE (the count is not restarted)
  - a wake event in ACTIVE
  - a `sleep_req` while asleep
- R12: Bit i of the gating register (written through `prr_we`/`prr_wdata`, taking effect at the next edge) set to 1 forces `periph_clk_en[i]`=0. Clearing the bit restores the enable. In depths other than Idle, every `periph_clk_en` bit is 0.
- R13: For a bus access whose one-hot `bus_sel` hits a gated peripheral, `periph_rd_en` and `periph_wr_en` are 0 and `bus_rdata_out` is 0. For an ungated peripheral the strobes pass to the selected bit and `bus_rdata_out` equals `bus_rdata_in`. Both cases are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mode_sel | input | 3 | Sleep depth code |
| sleep_req | input | 1 | Sleep strobe |
| wake_evt | input | 1 | Wake event |
| xtal_opt | input | 1 | External crystal clock option selected |
| t2_async | input | 1 | Timer 2 runs from its asynchronous source |
| prr_we | input | 1 | Gating register write strobe |
| prr_wdata | input | NPERIPH | Gating register write data |
| bus_sel | input | NPERIPH | One-hot peripheral select for a bus access |
| bus_rd | input | 1 | Bus read strobe |
| bus_wr | input | 1 | Bus write strobe |
| bus_rdata_in | input | DW | Read data from the selected peripheral |
| cpu_clk_en | output | 1 | CPU clock enable |
| io_clk_en | output | 1 | I/O clock enable |
| t2_clk_en | output | 1 | Timer-2 clock enable |
| osc_en | output | 1 | Main oscillator enable |
| periph_clk_en | output | NPERIPH | Per-peripheral clock enables |
| periph_rd_en | output | NPERIPH | Per-peripheral read strobes after blocking |
| periph_wr_en | output | NPERIPH | Per-peripheral write strobes after blocking |
| bus_rdata_out | output | DW | Read data returned to the bus |
| wake_done | output | 1 | One-cycle pulse on return to ACTIVE |

## Verification
Several properties are checked on every cycle:
- a reserved code never takes the CPU clock away.
- the countdown falls by exactly one each WAKE cycle, so a repeated wake event cannot reload it.
- `wake_done` never lasts two cycles.
- a one-hot bus select never yields more than one peripheral strobe.

The bench scenarios cover the rest, which is the enable pattern of each depth under both timer-clock sources and both crystal settings. They also cover the exact countdown lengths, the effect of the gating register across depths, and the zeroed read data of a blocked access.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
    typedef enum logic [2:0] {
        M_IDLE,
        M_ADCQ,
        M_PDOWN,
        M_PSAVE,
        M_STBY,
        M_XSTBY
    } smode_t;

    typedef enum logic [1:0] {
        ST_ACTIVE,
        ST_SLEEP,
        ST_WAKE
    } pstate_t;
endpackage

// File: rtl/pwr_mode_decode.sv
module pwr_mode_decode
    import pwr_pkg::*;
(
    input  logic [2:0] code,
    input  logic       xtal,
    output logic       valid,
    output smode_t     mode,
    output logic       shallow
);
    always_comb begin
        valid = 1'b1;
        mode  = M_IDLE;
        unique case (code)
            3'b000:  mode = M_IDLE;
            3'b001:  mode = M_ADCQ;
            3'b010:  mode = M_PDOWN;
            3'b011:  mode = M_PSAVE;
            3'b110:  mode = xtal ? M_STBY  : M_PDOWN;
            3'b111:  mode = xtal ? M_XSTBY : M_PSAVE;
            default: valid = 1'b0;
        endcase
        shallow = (mode == M_IDLE) || (mode == M_ADCQ);
    end
endmodule

// File: rtl/pwr_wake_timer.sv
module pwr_wake_timer #(
    parameter int MAXV = 16,
    localparam int CW = $clog2(MAXV + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic [CW-1:0] count,
    output logic          done
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count <= '0;
        else if (load)
            count <= load_val;
        else if (count != '0)
            count <= count - 1'b1;
    end

    assign done = (count == '0);

    // R10: countdown never exceeds the longest wake window
    a_r10_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        32'(count) <= MAXV);
endmodule

// File: rtl/pwr_gate_reg.sv
module pwr_gate_reg #(
    parameter int NPERIPH = 4,
    parameter int DW = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               prr_we,
    input  logic [NPERIPH-1:0] prr_wdata,
    input  logic               io_clk_en,
    input  logic [NPERIPH-1:0] bus_sel,
    input  logic               bus_rd,
    input  logic               bus_wr,
    input  logic [DW-1:0]      bus_rdata_in,
    output logic [NPERIPH-1:0] periph_clk_en,
    output logic [NPERIPH-1:0] periph_rd_en,
    output logic [NPERIPH-1:0] periph_wr_en,
    output logic [DW-1:0]      bus_rdata_out
);
    logic [NPERIPH-1:0] prr_q;
    logic               blocked;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            prr_q <= '0;
        else if (prr_we)
            prr_q <= prr_wdata;
    end

    for (genvar i = 0; i < NPERIPH; i++) begin : g_per
        assign periph_clk_en[i] = io_clk_en & ~prr_q[i];
        assign periph_rd_en[i]  = bus_sel[i] & bus_rd & ~prr_q[i];
        assign periph_wr_en[i]  = bus_sel[i] & bus_wr & ~prr_q[i];
    end

    assign blocked       = |(bus_sel & prr_q);
    assign bus_rdata_out = blocked ? '0 : bus_rdata_in;

    // R13: a one-hot select can reach at most one peripheral
    a_r13_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bus_sel) |-> $onehot0(periph_rd_en | periph_wr_en));
endmodule

// File: rtl/pwr_sleep_ctrl.sv
module pwr_sleep_ctrl
    import pwr_pkg::*;
#(
    parameter int NPERIPH   = 4,
    parameter int DW        = 8,
    parameter int FAST_WAKE = 6,
    parameter int SLOW_WAKE = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         mode_sel,
    input  logic               sleep_req,
    input  logic               wake_evt,
    input  logic               xtal_opt,
    input  logic               t2_async,
    input  logic               prr_we,
    input  logic [NPERIPH-1:0] prr_wdata,
    input  logic [NPERIPH-1:0] bus_sel,
    input  logic               bus_rd,
    input  logic               bus_wr,
    input  logic [DW-1:0]      bus_rdata_in,
    output logic               cpu_clk_en,
    output logic               io_clk_en,
    output logic               t2_clk_en,
    output logic               osc_en,
    output logic [NPERIPH-1:0] periph_clk_en,
    output logic [NPERIPH-1:0] periph_rd_en,
    output logic [NPERIPH-1:0] periph_wr_en,
    output logic [DW-1:0]      bus_rdata_out,
    output logic               wake_done
);
    localparam int MAXW = (FAST_WAKE > SLOW_WAKE) ? FAST_WAKE : SLOW_WAKE;
    localparam int CW   = $clog2(MAXW + 1);
    localparam logic [CW-1:0] FAST_LD = CW'(FAST_WAKE - 1);
    localparam logic [CW-1:0] SLOW_LD = CW'(SLOW_WAKE - 1);

    pstate_t       state, state_n;
    smode_t        mode_q, dec_mode;
    logic          dec_valid, dec_shallow, shallow_q;
    logic          tmr_load, tmr_done;
    logic [CW-1:0] tmr_val, tmr_cnt;

    pwr_mode_decode u_dec (
        .code    (mode_sel),
        .xtal    (xtal_opt),
        .valid   (dec_valid),
        .mode    (dec_mode),
        .shallow (dec_shallow)
    );

    pwr_wake_timer #(.MAXV(MAXW)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .count    (tmr_cnt),
        .done     (tmr_done)
    );

    pwr_gate_reg #(.NPERIPH(NPERIPH), .DW(DW)) u_gate (
        .clk           (clk),
        .rst_n         (rst_n),
        .prr_we        (prr_we),
        .prr_wdata     (prr_wdata),
        .io_clk_en     (io_clk_en),
        .bus_sel       (bus_sel),
        .bus_rd        (bus_rd),
        .bus_wr        (bus_wr),
        .bus_rdata_in  (bus_rdata_in),
        .periph_clk_en (periph_clk_en),
        .periph_rd_en  (periph_rd_en),
        .periph_wr_en  (periph_wr_en),
        .bus_rdata_out (bus_rdata_out)
    );

    // next state and countdown load
    always_comb begin
        state_n  = state;
        tmr_load = 1'b0;
        tmr_val  = ((mode_q == M_STBY) || (mode_q == M_XSTBY)) ? FAST_LD : SLOW_LD;
        unique case (state)
            ST_ACTIVE: if (sleep_req && dec_valid) state_n = ST_SLEEP;
            ST_SLEEP: begin
                if (wake_evt) begin
                    if (shallow_q) begin
                        state_n = ST_ACTIVE;
                    end else begin
                        state_n  = ST_WAKE;
                        tmr_load = 1'b1;
                    end
                end
            end
            ST_WAKE:   if (tmr_done) state_n = ST_ACTIVE;
            default:   state_n = ST_ACTIVE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_ACTIVE;
            mode_q    <= M_IDLE;
            shallow_q <= 1'b1;
            wake_done <= 1'b0;
        end else begin
            state     <= state_n;
            wake_done <= (state != ST_ACTIVE) && (state_n == ST_ACTIVE);
            if (state == ST_ACTIVE && sleep_req && dec_valid) begin
                mode_q    <= dec_mode;
                shallow_q <= dec_shallow;
            end
        end
    end

    // domain enables
    always_comb begin
        cpu_clk_en = 1'b0;
        io_clk_en  = 1'b0;
        t2_clk_en  = 1'b0;
        osc_en     = 1'b0;
        unique case (state)
            ST_ACTIVE: begin
                cpu_clk_en = 1'b1;
                io_clk_en  = 1'b1;
                t2_clk_en  = 1'b1;
                osc_en     = 1'b1;
            end
            ST_SLEEP, ST_WAKE: begin
                io_clk_en = (state == ST_SLEEP) && (mode_q == M_IDLE);
                osc_en    = (state == ST_WAKE) || (mode_q == M_IDLE) || (mode_q == M_ADCQ)
                            || (mode_q == M_STBY) || (mode_q == M_XSTBY);
                unique case (mode_q)
                    M_IDLE:                     t2_clk_en = 1'b1;
                    M_ADCQ, M_PSAVE, M_XSTBY:   t2_clk_en = t2_async;
                    default:                    t2_clk_en = 1'b0;
                endcase
            end
            default: ;
        endcase
    end

    // R2: a reserved code keeps the CPU clock running
    a_r2_reserved_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACTIVE && sleep_req && mode_sel[2:1] == 2'b10) |=> cpu_clk_en);

    // R11: a wake event during the countdown never reloads it
    a_r11_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAKE && $past(state) == ST_WAKE) |-> (tmr_cnt == $past(tmr_cnt) - 1'b1));

    // R10: the wake-done flag is a single-cycle pulse
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wake_done |=> !wake_done);

    // R12: no peripheral clock without the I/O clock
    a_r12_deep_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !io_clk_en |-> (periph_clk_en == '0));
endmodule

// File: tb/tb_pwr_sleep_ctrl.sv
module tb_pwr_sleep_ctrl;
    localparam int NP = 4;
    localparam int FW = 6;
    localparam int SW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] mode_sel = '0;
    logic sleep_req = 0, wake_evt = 0, xtal_opt = 0, t2_async = 0, prr_we = 0;
    logic [NP-1:0] prr_wdata = '0, bus_sel = '0;
    logic bus_rd = 0, bus_wr = 0;
    logic [7:0] bus_rdata_in = '0;
    logic cpu_clk_en, io_clk_en, t2_clk_en, osc_en, wake_done;
    logic [NP-1:0] periph_clk_en, periph_rd_en, periph_wr_en;
    logic [7:0] bus_rdata_out;

    pwr_sleep_ctrl #(.NPERIPH(NP), .DW(8), .FAST_WAKE(FW), .SLOW_WAKE(SW)) dut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .sleep_req(sleep_req),
        .wake_evt(wake_evt), .xtal_opt(xtal_opt), .t2_async(t2_async),
        .prr_we(prr_we), .prr_wdata(prr_wdata), .bus_sel(bus_sel),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata_in(bus_rdata_in),
        .cpu_clk_en(cpu_clk_en), .io_clk_en(io_clk_en), .t2_clk_en(t2_clk_en),
        .osc_en(osc_en), .periph_clk_en(periph_clk_en), .periph_rd_en(periph_rd_en),
        .periph_wr_en(periph_wr_en), .bus_rdata_out(bus_rdata_out), .wake_done(wake_done)
    );

    always #10 clk = ~clk;

    typedef struct {
        int          cyc;
        string       req;
        logic [8:0]  exp;
    } item_t;

    item_t q[$];
    int cyc = 0;
    int total = 0;
    int bad = 0;
    logic [3:0] gate = 4'b0000;
    bit finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [8:0] mk(bit c, bit i, bit t, bit o, bit w, logic [3:0] p);
        return {c, i, t, o, w, p};
    endfunction

    // monitor: pops expectations and compares at the falling edge
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].cyc < cyc) begin
            total++; bad++;
            $display("FAIL %s: expectation for cycle %0d missed", q[0].req, q[0].cyc);
            void'(q.pop_front());
        end
        if (q.size() > 0 && q[0].cyc == cyc) begin
            item_t it;
            logic [8:0] obs;
            it  = q.pop_front();
            obs = {cpu_clk_en, io_clk_en, t2_clk_en, osc_en, wake_done, periph_clk_en};
            total++;
            if (obs !== it.exp) begin
                bad++;
                $display("FAIL %s: cycle %0d got %b expected %b", it.req, cyc, obs, it.exp);
            end
        end
    end

    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic push(int d, string r, logic [8:0] v);
        q.push_back('{cyc + d, r, v});
    endtask

    function automatic logic [8:0] act(bit w);
        return mk(1, 1, 1, 1, w, ~gate);
    endfunction

    task automatic go_sleep(logic [2:0] code, string r, logic [8:0] v);
        mode_sel = code; sleep_req = 1;
        push(1, r, v);
        step();
        sleep_req = 0;
    endtask

    task automatic wake_fast(string r);
        wake_evt = 1;
        push(1, r, act(1));
        push(2, r, act(0));
        step();
        wake_evt = 0;
        step();
    endtask

    task automatic wake_slow(int n, string r, logic [8:0] wv, bit again);
        wake_evt = 1;
        for (int k = 1; k <= n; k++) push(k, r, wv);
        push(n + 1, r, act(1));
        push(n + 2, r, act(0));
        for (int k = 1; k <= n + 2; k++) begin
            step();
            wake_evt = (again && (k == 2 || k == 4));
        end
        wake_evt = 0;
    endtask

    task automatic chk_bus(string r, logic [3:0] sel, bit rd, bit wr, logic [7:0] din,
                           logic [3:0] erd, logic [3:0] ewr, logic [7:0] eout);
        bus_sel = sel; bus_rd = rd; bus_wr = wr; bus_rdata_in = din;
        #1;
        total++;
        if (periph_rd_en !== erd || periph_wr_en !== ewr || bus_rdata_out !== eout) begin
            bad++;
            $display("FAIL %s: rd=%b wr=%b dout=%h expected rd=%b wr=%b dout=%h",
                     r, periph_rd_en, periph_wr_en, bus_rdata_out, erd, ewr, eout);
        end
        bus_sel = '0; bus_rd = 0; bus_wr = 0;
    endtask

    task automatic write_gate(logic [3:0] v, string r);
        prr_we = 1; prr_wdata = v;
        gate = v;
        push(1, r, act(0));
        step();
        prr_we = 0;
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1;
        push(1, "R1", act(0));
        step();

        // R2 reserved codes
        go_sleep(3'b100, "R2", act(0));
        go_sleep(3'b101, "R2", act(0));

        // R11 wake event while running
        wake_evt = 1; push(1, "R11", act(0)); step(); wake_evt = 0;

        // R3 Idle
        go_sleep(3'b000, "R3", mk(0, 1, 1, 1, 0, 4'hF));
        wake_fast("R3");

        // R4 ADC-quiet, both timer sources
        t2_async = 1;
        go_sleep(3'b001, "R4", mk(0, 0, 1, 1, 0, 4'h0));
        wake_fast("R4");
        t2_async = 0;
        go_sleep(3'b001, "R4", mk(0, 0, 0, 1, 0, 4'h0));
        wake_fast("R4");

        // R5 Power-down with slow wake
        go_sleep(3'b010, "R5", mk(0, 0, 0, 0, 0, 4'h0));
        wake_slow(SW, "R5", mk(0, 0, 0, 1, 0, 4'h0), 0);

        // R6 Power-save, asynchronous then synchronous timer clock
        t2_async = 1;
        go_sleep(3'b011, "R6", mk(0, 0, 1, 0, 0, 4'h0));
        wake_slow(SW, "R6", mk(0, 0, 1, 1, 0, 4'h0), 0);
        t2_async = 0;
        go_sleep(3'b011, "R6", mk(0, 0, 0, 0, 0, 4'h0));
        wake_slow(SW, "R6", mk(0, 0, 0, 1, 0, 4'h0), 0);

        // R7 Standby, plus R11 ignored sleep request and absorbed wake events
        xtal_opt = 1;
        go_sleep(3'b110, "R7", mk(0, 0, 0, 1, 0, 4'h0));
        go_sleep(3'b000, "R11", mk(0, 0, 0, 1, 0, 4'h0));
        wake_slow(FW, "R7", mk(0, 0, 0, 1, 0, 4'h0), 1);

        // R8 Extended Standby
        t2_async = 1;
        go_sleep(3'b111, "R8", mk(0, 0, 1, 1, 0, 4'h0));
        wake_slow(FW, "R8", mk(0, 0, 1, 1, 0, 4'h0), 0);

        // R9 fallbacks without crystal
        xtal_opt = 0;
        go_sleep(3'b110, "R9", mk(0, 0, 0, 0, 0, 4'h0));
        wake_slow(SW, "R9", mk(0, 0, 0, 1, 0, 4'h0), 0);
        go_sleep(3'b111, "R9", mk(0, 0, 1, 0, 0, 4'h0));
        wake_slow(SW, "R9", mk(0, 0, 1, 1, 0, 4'h0), 0);
        t2_async = 0;

        // R12 gating register across depths
        write_gate(4'b0101, "R12");
        go_sleep(3'b000, "R12", mk(0, 1, 1, 1, 0, 4'b1010));
        wake_fast("R12");
        go_sleep(3'b010, "R12", mk(0, 0, 0, 0, 0, 4'h0));
        wake_slow(SW, "R12", mk(0, 0, 0, 1, 0, 4'h0), 0);

        // R13 bus blocking with bits 0 and 2 gated
        chk_bus("R13", 4'b0001, 1, 0, 8'hA5, 4'b0000, 4'b0000, 8'h00);
        chk_bus("R13", 4'b0010, 1, 0, 8'hA5, 4'b0010, 4'b0000, 8'hA5);
        chk_bus("R13", 4'b0100, 0, 1, 8'h3C, 4'b0000, 4'b0000, 8'h00);
        chk_bus("R13", 4'b1000, 0, 1, 8'h3C, 4'b0000, 4'b1000, 8'h3C);

        write_gate(4'b0000, "R12");
        chk_bus("R13", 4'b0001, 1, 0, 8'h77, 4'b0001, 4'b0000, 8'h77);

        while (q.size() > 0) step();
        step();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: run did not complete");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule